// File: doc/BRIEF.md
# Partitioned Buffer Admission Controller

This block decides whether a frame may occupy one of the slots of a buffer memory, and which part of the memory pays for that slot. The slots are split into a holding area for frames that are not yet classified, a reservation for each of the six upper traffic classes, a reservation for each of the four source ports, and one common pool. The block holds only occupancy counts and region sizes. It never touches frame data.

A frame that arrives takes a holding slot at once, or it is refused if the holding area is full. When the classification result arrives with the frame's class and source port, the frame leaves the holding area. The controller then tries the regions in a fixed order: the class reservation first, then the source-port reservation, then the common pool. It reports the region that was charged, or a drop if every candidate is full. When a frame leaves the buffer, the region code it was charged to is returned on the release interface. Because the regions are checked in this order, a port or class that floods the buffer can use up only its own reservations and the common pool. The reservations of other ports and classes stay available to them.

Top module: `buf_admit_ctrl`

## Requirements
- R1: After a synchronous reset, all occupancy outputs are zero, and `arrive_refuse`, `grant_valid` and `drop` are low.
- R2: An arrival while the holding count is below `cfg_temp_size` adds one to `occ_temp`. An arrival while the holding count is at or above that size leaves `occ_temp` unchanged and raises `arrive_refuse` for one cycle on the next clock edge.
- R3: A classification removes one frame from the holding count, whatever the outcome. The holding count never goes below zero.
- R4: A frame of class 2 to 7 whose class region has a free slot is charged to that region, and `grant_region` equals the class number (codes 2 to 7).
- R5: Classes 0 and 1 have no class region. Their frames are tried at the port region first, and a grant for them never carries a code below 8.
- R6: When the class region is full or absent, a frame is charged to the region of its source port if that region has room, with code 8 plus the port number (8 to 11).
- R7: When both the class region and the port region are full, a frame is charged to the common pool, with code 12.
- R8: When no candidate region has room, `drop` is raised and no region count changes.
- R9: A release with code 2 to 12 lowers that region's count by one, and a count of zero stays at zero. Codes 0, 1, 13, 14 and 15 change no count.
- R10: An allocate and a release that hit the same region in the same cycle leave its count unchanged. This also holds for an arrival and a classification in the same cycle on the holding count.
- R11: No region count ever exceeds its configured size.
- R12: `grant_valid`, `grant_region` and `drop` are registered and appear on the clock edge that samples the classification. `grant_valid` and `drop` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arrive_valid | input | 1 | A new frame requests a holding slot |
| arrive_refuse | output | 1 | The previous arrival was refused because the holding area was full |
| classify_valid | input | 1 | Classification result for one held frame |
| classify_class | input | 3 | Traffic class of the frame, 0 to 7 |
| classify_port | input | 2 | Source port of the frame, 0 to 3 |
| grant_valid | output | 1 | The classified frame was admitted |
| grant_region | output | 4 | Code of the region that was charged |
| drop | output | 1 | The classified frame must be discarded |
| release_valid | input | 1 | A frame leaves the buffer |
| release_region | input | 4 | Region code that the leaving frame was charged to |
| cfg_temp_size | input | 8 | Holding area size |
| cfg_class_size | input | 48 | Sizes for classes 2 to 7, 8 bits each, class 2 in the low byte |
| cfg_port_size | input | 32 | Sizes for ports 0 to 3, 8 bits each, port 0 in the low byte |
| cfg_shared_size | input | 8 | Common pool size |
| occ_temp | output | 8 | Holding area occupancy |
| occ_class | output | 48 | Class region occupancies, same layout as the sizes |
| occ_port | output | 32 | Port region occupancies, same layout as the sizes |
| occ_shared | output | 8 | Common pool occupancy |

## Verification
The case that is hardest to reach is the full fall-through. A frame can only be dropped when its class region, its port region and the common pool are all full at once. Every one of those slots has to come from a frame that first passed through the small holding area. To get there, the stimulus fills the holding area, then classifies frames of one class and one port until each region overflows into the next. It keeps classifying after the holding count has reached zero, to check that the count stops at zero. After that it releases a single common-pool slot and, in the same cycle, charges a new frame to the same region, which exercises the same-cycle rule.

// File: rtl/buf_admit_pkg.sv
`timescale 1ns/1ps
package buf_admit_pkg;
  localparam int NUM_CLASSES = 8;
  localparam int NUM_PORTS   = 4;
  localparam int RSV_LO      = 2;
  localparam int NRSV        = NUM_CLASSES - RSV_LO;
  localparam int CLS_W       = $clog2(NUM_CLASSES);
  localparam int PORT_W      = $clog2(NUM_PORTS);
  localparam int PORT_BASE   = NUM_CLASSES;
  localparam int SHARED_CODE = PORT_BASE + NUM_PORTS;
  localparam int CODE_W      = $clog2(SHARED_CODE + 1);
  typedef logic [CODE_W-1:0] region_code_t;
endpackage

// File: rtl/buf_region_ctr.sv
`timescale 1ns/1ps
module buf_region_ctr #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] size,
  input  logic          inc,
  input  logic          dec,
  output logic [CW-1:0] count,
  output logic          room
);
  assign room = (count < size);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else begin
      case ({inc, dec})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= (count == '0) ? '0 : count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  a_r11_no_overflow: assert property (@(posedge clk) disable iff (rst)
    inc |-> (count < size));
  a_r9_floor: assert property (@(posedge clk) disable iff (rst)
    (dec && !inc && count == '0) |=> (count == '0));
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    (inc && dec) |=> (count == $past(count)));
endmodule

// File: rtl/buf_region_decode.sv
`timescale 1ns/1ps
module buf_region_decode
  import buf_admit_pkg::*;
(
  input  logic                 valid,
  input  region_code_t         code,
  output logic [NRSV-1:0]      cls_hit,
  output logic [NUM_PORTS-1:0] port_hit,
  output logic                 shared_hit
);
  genvar gi;
  generate
    for (gi = 0; gi < NRSV; gi++) begin : g_cls
      assign cls_hit[gi] = valid && (code == CODE_W'(gi + RSV_LO));
    end
    for (gi = 0; gi < NUM_PORTS; gi++) begin : g_port
      assign port_hit[gi] = valid && (code == CODE_W'(gi + PORT_BASE));
    end
  endgenerate
  assign shared_hit = valid && (code == CODE_W'(SHARED_CODE));
endmodule

// File: rtl/buf_admit_select.sv
`timescale 1ns/1ps
module buf_admit_select
  import buf_admit_pkg::*;
(
  input  logic [CLS_W-1:0]     cls,
  input  logic [PORT_W-1:0]    port,
  input  logic [NRSV-1:0]      class_room,
  input  logic [NUM_PORTS-1:0] port_room,
  input  logic                 shared_room,
  output region_code_t         code,
  output logic                 drop
);
  logic [NUM_CLASSES-1:0] room_all;
  assign room_all = {class_room, {RSV_LO{1'b0}}};

  always_comb begin
    drop = 1'b0;
    code = '0;
    if (room_all[cls]) begin
      code = CODE_W'(cls);
    end else if (port_room[port]) begin
      code = CODE_W'(PORT_BASE) + CODE_W'(port);
    end else if (shared_room) begin
      code = CODE_W'(SHARED_CODE);
    end else begin
      drop = 1'b1;
    end
  end
endmodule

// File: rtl/buf_admit_ctrl.sv
`timescale 1ns/1ps
module buf_admit_ctrl
  import buf_admit_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      arrive_valid,
  output logic                      arrive_refuse,
  input  logic                      classify_valid,
  input  logic [CLS_W-1:0]          classify_class,
  input  logic [PORT_W-1:0]         classify_port,
  output logic                      grant_valid,
  output logic [CODE_W-1:0]         grant_region,
  output logic                      drop,
  input  logic                      release_valid,
  input  logic [CODE_W-1:0]         release_region,
  input  logic [CW-1:0]             cfg_temp_size,
  input  logic [NRSV*CW-1:0]        cfg_class_size,
  input  logic [NUM_PORTS*CW-1:0]   cfg_port_size,
  input  logic [CW-1:0]             cfg_shared_size,
  output logic [CW-1:0]             occ_temp,
  output logic [NRSV*CW-1:0]        occ_class,
  output logic [NUM_PORTS*CW-1:0]   occ_port,
  output logic [CW-1:0]             occ_shared
);
  logic                 temp_room, temp_inc;
  logic [NRSV-1:0]      class_room, alloc_cls, rel_cls;
  logic [NUM_PORTS-1:0] port_room, alloc_port, rel_port;
  logic                 shared_room, alloc_sh, rel_sh;
  region_code_t         sel_code;
  logic                 sel_drop, take;

  assign temp_inc = arrive_valid && temp_room;
  assign take     = classify_valid && !sel_drop;

  buf_region_ctr #(.CW(CW)) u_temp (
    .clk(clk), .rst(rst), .size(cfg_temp_size), .inc(temp_inc),
    .dec(classify_valid), .count(occ_temp), .room(temp_room));

  buf_admit_select u_sel (
    .cls(classify_class), .port(classify_port), .class_room(class_room),
    .port_room(port_room), .shared_room(shared_room),
    .code(sel_code), .drop(sel_drop));

  buf_region_decode u_alloc_dec (
    .valid(take), .code(sel_code), .cls_hit(alloc_cls),
    .port_hit(alloc_port), .shared_hit(alloc_sh));

  buf_region_decode u_rel_dec (
    .valid(release_valid), .code(release_region), .cls_hit(rel_cls),
    .port_hit(rel_port), .shared_hit(rel_sh));

  genvar gi;
  generate
    for (gi = 0; gi < NRSV; gi++) begin : g_cls_ctr
      buf_region_ctr #(.CW(CW)) u_ctr (
        .clk(clk), .rst(rst), .size(cfg_class_size[gi*CW +: CW]),
        .inc(alloc_cls[gi]), .dec(rel_cls[gi]),
        .count(occ_class[gi*CW +: CW]), .room(class_room[gi]));
    end
    for (gi = 0; gi < NUM_PORTS; gi++) begin : g_port_ctr
      buf_region_ctr #(.CW(CW)) u_ctr (
        .clk(clk), .rst(rst), .size(cfg_port_size[gi*CW +: CW]),
        .inc(alloc_port[gi]), .dec(rel_port[gi]),
        .count(occ_port[gi*CW +: CW]), .room(port_room[gi]));
    end
  endgenerate

  buf_region_ctr #(.CW(CW)) u_shared (
    .clk(clk), .rst(rst), .size(cfg_shared_size), .inc(alloc_sh),
    .dec(rel_sh), .count(occ_shared), .room(shared_room));

  always_ff @(posedge clk) begin
    if (rst) begin
      arrive_refuse <= 1'b0;
      grant_valid   <= 1'b0;
      grant_region  <= '0;
      drop          <= 1'b0;
    end else begin
      arrive_refuse <= arrive_valid && !temp_room;
      grant_valid   <= take;
      grant_region  <= take ? sel_code : '0;
      drop          <= classify_valid && sel_drop;
    end
  end

  a_r2_refuse_full: assert property (@(posedge clk) disable iff (rst)
    (arrive_valid && occ_temp >= cfg_temp_size) |=> arrive_refuse);
  a_r5_low_class_no_class_region: assert property (@(posedge clk) disable iff (rst)
    (classify_valid && classify_class < CLS_W'(RSV_LO)) |=>
      !(grant_valid && grant_region < CODE_W'(PORT_BASE)));
  a_r8_drop_no_change: assert property (@(posedge clk) disable iff (rst)
    (classify_valid && !release_valid && sel_drop) |=>
      ($stable(occ_class) && $stable(occ_port) && $stable(occ_shared)));
  always_comb begin
    if (!rst) a_r12_exclusive: assert (!(grant_valid && drop));
  end
endmodule

// File: tb/test_buf_admit_ctrl.sv
`timescale 1ns/1ps
module test_buf_admit_ctrl;
  localparam int CW = 8;
  logic clk = 1'b0, rst = 1'b1;
  logic arrive_valid = 0, classify_valid = 0, release_valid = 0;
  logic [2:0] classify_class = 0;
  logic [1:0] classify_port = 0;
  logic [3:0] release_region = 0;
  logic arrive_refuse, grant_valid, drop;
  logic [3:0] grant_region;
  logic [CW-1:0] cfg_temp_size, cfg_shared_size, occ_temp, occ_shared;
  logic [47:0] cfg_class_size, occ_class;
  logic [31:0] cfg_port_size, occ_port;

  always #2.5 clk = ~clk;

  buf_admit_ctrl #(.CW(CW)) i_buf_admit_ctrl (.*);

  typedef struct packed {
    logic refuse; logic gv; logic [3:0] rgn; logic drp;
    logic [7:0] tmp; logic [47:0] cls; logic [31:0] prt; logic [7:0] sh;
  } exp_t;
  exp_t  exp_q[$];
  string tag_q[$];
  int vectors = 0, miscompares = 0;
  int m[13];
  int sz[13];
  int tmp = 0;
  int tsz = 4;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] expv);
    vectors++;
    if (act !== expv) begin
      miscompares++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic step(input bit arr, input bit cv, input int c, input int p,
                      input bit rv, input int rc, input string tag);
    exp_t e;
    int code, rdec;
    bit ti;
    @(negedge clk);
    arrive_valid = arr; classify_valid = cv;
    classify_class = 3'(c); classify_port = 2'(p);
    release_valid = rv; release_region = 4'(rc);
    e = '0;
    e.refuse = arr && (tmp >= tsz);
    ti = arr && !e.refuse;
    if (ti && !cv) tmp++;
    else if (cv && !ti && tmp > 0) tmp--;
    code = -1;
    if (cv) begin
      if (c >= 2 && m[c] < sz[c]) code = c;
      else if (m[8+p] < sz[8+p]) code = 8 + p;
      else if (m[12] < sz[12]) code = 12;
    end
    e.gv  = cv && (code >= 0);
    e.drp = cv && (code < 0);
    e.rgn = e.gv ? 4'(code) : 4'd0;
    rdec = (rv && rc >= 2 && rc <= 12) ? rc : -1;
    for (int r = 2; r <= 12; r++) begin
      if (r == code && r != rdec) m[r]++;
      else if (r == rdec && r != code && m[r] > 0) m[r]--;
    end
    e.tmp = 8'(tmp);
    for (int i = 0; i < 6; i++) e.cls[i*8 +: 8] = 8'(m[i+2]);
    for (int i = 0; i < 4; i++) e.prt[i*8 +: 8] = 8'(m[i+8]);
    e.sh = 8'(m[12]);
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  // monitor: pops one expectation per driven cycle, away from the edge
  always @(posedge clk) begin
    exp_t e;
    string t;
    #1;
    if (!rst) chk("R12 grant and drop exclusive", 64'(grant_valid && drop), 64'd0);
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk({t, " refuse"}, 64'(arrive_refuse), 64'(e.refuse));
      chk({t, " grant"}, 64'(grant_valid), 64'(e.gv));
      chk({t, " region"}, 64'(grant_region), 64'(e.rgn));
      chk({t, " drop"}, 64'(drop), 64'(e.drp));
      chk({t, " occ_temp"}, 64'(occ_temp), 64'(e.tmp));
      chk({t, " occ_class R11"}, 64'(occ_class), 64'(e.cls));
      chk({t, " occ_port R11"}, 64'(occ_port), 64'(e.prt));
      chk({t, " occ_shared R11"}, 64'(occ_shared), 64'(e.sh));
    end
  end

  initial begin
    #(5.0 * 100000);
    miscompares++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    int csz[6] = '{1, 1, 2, 0, 1, 1};
    for (int r = 0; r < 13; r++) begin m[r] = 0; sz[r] = 0; end
    for (int i = 0; i < 6; i++) begin sz[i+2] = csz[i]; cfg_class_size[i*8 +: 8] = 8'(csz[i]); end
    for (int i = 0; i < 4; i++) begin sz[i+8] = 2; cfg_port_size[i*8 +: 8] = 8'd2; end
    sz[12] = 3; cfg_shared_size = 8'd3; cfg_temp_size = 8'(tsz);
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk("R1 reset occ_temp", 64'(occ_temp), 64'd0);
    chk("R1 reset occ_class", 64'(occ_class), 64'd0);
    chk("R1 reset occ_port", 64'(occ_port), 64'd0);
    chk("R1 reset occ_shared", 64'(occ_shared), 64'd0);
    chk("R1 reset flags", 64'({arrive_refuse, grant_valid, drop}), 64'd0);
    for (int k = 0; k < 4; k++) step(1, 0, 0, 0, 0, 0, "R2 arrival accepted");
    step(1, 0, 0, 0, 0, 0, "R2 arrival refused when holding area full");
    step(0, 1, 3, 0, 0, 0, "R4 R3 class 3 into its own region");
    step(0, 1, 3, 0, 0, 0, "R6 full class falls to port 0");
    step(0, 1, 0, 1, 0, 0, "R5 class 0 skips class regions");
    step(0, 1, 5, 0, 0, 0, "R6 zero-size class falls to port 0");
    step(0, 1, 5, 0, 0, 0, "R7 full port falls to shared pool");
    step(0, 1, 1, 2, 0, 0, "R3 holding count floor with R5 port 2");
    step(0, 1, 1, 2, 0, 0, "R5 port 2 second slot");
    step(0, 1, 1, 2, 0, 0, "R7 port 2 full to shared");
    step(0, 1, 1, 2, 0, 0, "R7 shared last slot");
    step(0, 1, 1, 2, 0, 0, "R8 R11 everything full drops");
    step(0, 0, 0, 0, 1, 12, "R9 release shared slot");
    step(0, 1, 1, 2, 1, 12, "R10 allocate and release shared together");
    step(0, 0, 0, 0, 1, 0, "R9 code 0 ignored");
    step(0, 0, 0, 0, 1, 13, "R9 code 13 ignored");
    step(0, 0, 0, 0, 1, 4, "R9 empty region stays at zero");
    step(0, 0, 0, 0, 1, 8, "R9 release port 0");
    step(1, 1, 7, 3, 0, 0, "R10 arrival and classification together");
    step(1, 0, 0, 0, 0, 0, "R2 arrival after drain");
    step(0, 0, 0, 0, 0, 0, "R12 idle cycle no output");
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule